// File: doc/BRIEF.md
# Coefficient Segmentation Converter

This block splits each filter coefficient `h` into a signed power-of-two term `s` and a small residual `m`, so that `h = s + m`. A filter datapath can then apply `s` with a shifter and send only `m` through the multiplier. Because `m` is much smaller than `h`, fewer multiplier bits toggle. Coefficients arrive one at a time on a ready/valid input. For each one the block steps an exponent counter upward from zero until `2^i` reaches the coefficient magnitude. It then applies one of two selection rules and presents one registered result.

The result is a shift exponent, a sign bit for the power-of-two term, a flag that marks the term as absent (for a zero coefficient), and the residual as a two's complement word as wide as the coefficient. The block counts results. After every `NUM_COEF` results it pulses a completion flag, and the count then restarts for the next coefficient set.

Top module: `coef_segmenter`

## Requirements
- R1: `coef_ready` is high whenever the unit is idle. A coefficient is taken on a clock edge where `coef_valid` and `coef_ready` are both high. `coef_ready` then stays low until that coefficient's result appears. Input values presented while it is low have no effect.
- R2: Let `i` be the smallest value with `2^i >= |h|` (`i = 0` for `|h| <= 1`). `seg_valid` goes high for exactly one cycle, `i+1` clock edges after the accepting edge. In that same cycle `coef_ready` is high again.
- R3: Nearest rule (`seg_mode = 0` when accepted). Take `|h|`. If `|h| = 2^i`, or if `2^i - |h| < |h| - 2^(i-1)`, the term is `2^i`. Otherwise the term is `2^(i-1)`, so a tie goes to the lower power. The residual magnitude is `|h|` minus the term.
- R4: Nearest rule with a negative `h`: both the term and the residual from R3 are negated, so `seg_neg = 1`.
- R5: Two's complement rule (`seg_mode = 1` when accepted). When `|h|` is an exact power of two, the term equals `h` and the residual is 0. This includes the most negative code `-2^(W-1)`, which gives exponent `W-1` and `seg_neg = 1`.
- R6: Two's complement rule with a positive `h` that is not a power of two: the term is `+2^(i-1)` and the residual is `h - 2^(i-1)`.
- R7: Two's complement rule with a negative `h` that is not a power of two: the term is `-2^i` and the residual is `h + 2^i`. The residual is never negative in this rule.
- R8: A zero coefficient gives `seg_zero = 1`, `seg_exp = 0`, `seg_neg = 0`, `seg_resid = 0` after one search step, in either mode.
- R9: For every nonzero result, `h = (seg_neg ? -1 : 1) * 2^seg_exp + seg_resid`, with `seg_resid` read as a signed W-bit value.
- R10: `run_done` is high for one cycle, on the cycle right after the `NUM_COEF`-th result since reset or since the previous `run_done`.
- R11: The mode and the coefficient are sampled only on the accepting edge. Changing `seg_mode` or `coef_in` while a search is in progress does not change that coefficient's result.
- R12: A synchronous active-high reset clears `seg_valid`, `run_done` and all result fields to 0, sets `coef_ready` to 1, and restarts the result count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_valid | input | 1 | A coefficient is offered on `coef_in` |
| coef_in | input | COEF_W | Coefficient, two's complement |
| seg_mode | input | 1 | 0 = nearest-power rule, 1 = two's complement rule |
| coef_ready | output | 1 | Unit is idle and will take a coefficient |
| seg_valid | output | 1 | One-cycle strobe: result fields are valid |
| seg_exp | output | $clog2(COEF_W) | Exponent of the power-of-two term |
| seg_neg | output | 1 | Power-of-two term is negative |
| seg_zero | output | 1 | Coefficient was zero; no power-of-two term |
| seg_resid | output | COEF_W | Residual, signed two's complement |
| run_done | output | 1 | One-cycle pulse after the last result of a set |

## Verification
The hardest cases to reach from the ports are those near the selection boundaries. These are the exact tie between the two candidate powers in the nearest rule (for example 6, 12, -24) and the most negative code, whose magnitude does not fit the signed range. Directed values placed at each boundary reach them, and pseudo-random coefficients with their magnitudes scaled down cover every search length. A mode flip and a junk coefficient applied in the middle of a search show that the sampled values are held. A reset in the middle of a set confirms that the completion count restarts.

// File: rtl/coefseg_pkg.sv
package coefseg_pkg;

  typedef enum logic {
    SEG_NEAREST = 1'b0,
    SEG_TWOS    = 1'b1
  } seg_mode_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } seq_state_e;

endpackage

// File: rtl/coefseg_scan.sv
module coefseg_scan #(
  parameter int COEF_W = 16,
  localparam int EXP_W = $clog2(COEF_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [COEF_W-1:0] coef,
  output logic [COEF_W-1:0] mag,
  output logic [EXP_W-1:0]  idx,
  output logic              hit
);

  logic [COEF_W-1:0] pow;

  // magnitude of the incoming word; the most negative code maps to 2^(W-1)
  always_ff @(posedge clk) begin
    if (rst) begin
      mag <= '0;
      idx <= '0;
    end else if (load) begin
      mag <= coef[COEF_W-1] ? (~coef + COEF_W'(1)) : coef;
      idx <= '0;
    end else if (step) begin
      idx <= idx + EXP_W'(1);
    end
  end

  assign pow = COEF_W'(1) << idx;
  assign hit = (pow >= mag);

endmodule

// File: rtl/coefseg_select.sv
module coefseg_select
  import coefseg_pkg::*;
#(
  parameter int COEF_W = 16,
  localparam int EXP_W = $clog2(COEF_W),
  localparam int XW    = COEF_W + 2
) (
  input  logic [COEF_W-1:0] coef,
  input  logic [COEF_W-1:0] mag,
  input  logic [EXP_W-1:0]  idx,
  input  seg_mode_e         mode,
  output logic [EXP_W-1:0]  exp_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic [COEF_W-1:0] resid_o
);

  logic [COEF_W-1:0]    pow, half, up_gap, dn_gap;
  logic                 exact, go_up;
  logic [EXP_W-1:0]     idx_dn;
  logic signed [XW-1:0] coef_x, mag_x, pow_x, half_x, mres, res_x;

  assign pow    = COEF_W'(1) << idx;
  assign half   = pow >> 1;
  assign exact  = (pow == mag);
  assign up_gap = pow - mag;
  assign dn_gap = mag - half;
  assign go_up  = exact || (up_gap < dn_gap);
  assign idx_dn = idx - EXP_W'(1);

  assign coef_x = {{2{coef[COEF_W-1]}}, coef};
  assign mag_x  = {2'b00, mag};
  assign pow_x  = {2'b00, pow};
  assign half_x = {2'b00, half};
  assign mres   = mag_x - (go_up ? pow_x : half_x);

  always_comb begin
    exp_o  = '0;
    neg_o  = 1'b0;
    zero_o = 1'b0;
    res_x  = '0;
    if (mag == '0) begin
      zero_o = 1'b1;
    end else if (mode == SEG_NEAREST) begin
      exp_o = go_up ? idx : idx_dn;
      neg_o = coef[COEF_W-1];
      res_x = coef[COEF_W-1] ? -mres : mres;
    end else if (exact) begin
      exp_o = idx;
      neg_o = coef[COEF_W-1];
    end else if (!coef[COEF_W-1]) begin
      exp_o = idx_dn;
      res_x = coef_x - half_x;
    end else begin
      exp_o = idx;
      neg_o = 1'b1;
      res_x = coef_x + pow_x;
    end
  end

  assign resid_o = res_x[COEF_W-1:0];

endmodule

// File: rtl/coefseg_sequencer.sv
module coefseg_sequencer
  import coefseg_pkg::*;
#(
  parameter int NUM_COEF = 8,
  localparam int K_W = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic coef_valid,
  input  logic hit,
  output logic ready,
  output logic load,
  output logic step,
  output logic emit,
  output logic run_done
);

  seq_state_e     state;
  logic [K_W-1:0] k_cnt;
  logic           last_k, last_pend;

  assign ready  = (state == ST_IDLE);
  assign load   = ready && coef_valid;
  assign step   = (state == ST_SEARCH) && !hit;
  assign emit   = (state == ST_SEARCH) && hit;
  assign last_k = (k_cnt == K_W'(NUM_COEF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      k_cnt     <= '0;
      last_pend <= 1'b0;
      run_done  <= 1'b0;
    end else begin
      run_done  <= last_pend;
      last_pend <= emit && last_k;
      if (load) begin
        state <= ST_SEARCH;
      end else if (emit) begin
        state <= ST_IDLE;
        k_cnt <= last_k ? '0 : k_cnt + K_W'(1);
      end
    end
  end

endmodule

// File: rtl/coef_segmenter.sv
module coef_segmenter
  import coefseg_pkg::*;
#(
  parameter int COEF_W   = 16,
  parameter int NUM_COEF = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       coef_valid,
  input  logic [COEF_W-1:0]          coef_in,
  input  logic                       seg_mode,
  output logic                       coef_ready,
  output logic                       seg_valid,
  output logic [$clog2(COEF_W)-1:0]  seg_exp,
  output logic                       seg_neg,
  output logic                       seg_zero,
  output logic [COEF_W-1:0]          seg_resid,
  output logic                       run_done
);

  localparam int EXP_W = $clog2(COEF_W);

  logic              load, step, emit, hit;
  logic [COEF_W-1:0] coef_q, mag;
  logic [EXP_W-1:0]  idx;
  seg_mode_e         mode_q;
  logic [EXP_W-1:0]  sel_exp;
  logic              sel_neg, sel_zero;
  logic [COEF_W-1:0] sel_resid;

  coefseg_sequencer #(.NUM_COEF(NUM_COEF)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .coef_valid (coef_valid),
    .hit        (hit),
    .ready      (coef_ready),
    .load       (load),
    .step       (step),
    .emit       (emit),
    .run_done   (run_done)
  );

  coefseg_scan #(.COEF_W(COEF_W)) u_scan (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .step (step),
    .coef (coef_in),
    .mag  (mag),
    .idx  (idx),
    .hit  (hit)
  );

  coefseg_select #(.COEF_W(COEF_W)) u_sel (
    .coef    (coef_q),
    .mag     (mag),
    .idx     (idx),
    .mode    (mode_q),
    .exp_o   (sel_exp),
    .neg_o   (sel_neg),
    .zero_o  (sel_zero),
    .resid_o (sel_resid)
  );

  // coefficient and rule are held from the accepting edge until the result
  always_ff @(posedge clk) begin
    if (rst) begin
      coef_q <= '0;
      mode_q <= SEG_NEAREST;
    end else if (load) begin
      coef_q <= coef_in;
      mode_q <= seg_mode_e'(seg_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_valid <= 1'b0;
      seg_exp   <= '0;
      seg_neg   <= 1'b0;
      seg_zero  <= 1'b0;
      seg_resid <= '0;
    end else begin
      seg_valid <= emit;
      if (emit) begin
        seg_exp   <= sel_exp;
        seg_neg   <= sel_neg;
        seg_zero  <= sel_zero;
        seg_resid <= sel_resid;
      end
    end
  end

endmodule

// File: rtl/coef_segmenter_chk.sv
module coef_segmenter_chk #(
  parameter int COEF_W = 16,
  localparam int EXP_W = $clog2(COEF_W),
  localparam int XW    = COEF_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              coef_valid,
  input logic              coef_ready,
  input logic              seg_valid,
  input logic [EXP_W-1:0]  seg_exp,
  input logic              seg_neg,
  input logic              seg_zero,
  input logic [COEF_W-1:0] seg_resid,
  input logic              run_done,
  input logic [COEF_W-1:0] coef_q,
  input logic              mode_q
);

  logic signed [XW-1:0] pow_x, res_x, coef_x, sum_x, res_abs;

  assign pow_x   = XW'(1) << seg_exp;
  assign res_x   = {{2{seg_resid[COEF_W-1]}}, seg_resid};
  assign coef_x  = {{2{coef_q[COEF_W-1]}}, coef_q};
  assign sum_x   = (seg_neg ? -pow_x : pow_x) + res_x;
  assign res_abs = res_x[XW-1] ? -res_x : res_x;

  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    coef_valid && coef_ready |=> !coef_ready);

  a_r2_one_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
    seg_valid |=> !seg_valid);

  a_r2_ready_with_result: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> coef_ready);

  a_r3_resid_bounded: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !mode_q && !seg_zero |-> res_abs <= (pow_x >>> 1));

  a_r7_twos_resid_nonneg: assert property (@(posedge clk) disable iff (rst)
    seg_valid && mode_q && !seg_zero |-> !seg_resid[COEF_W-1]);

  a_r8_zero_fields: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_zero |-> (seg_resid == '0) && !seg_neg && (seg_exp == '0));

  a_r9_recombine: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !seg_zero |-> sum_x == coef_x);

  a_r10_done_follows_result: assert property (@(posedge clk) disable iff (rst)
    run_done |-> $past(seg_valid));

endmodule

bind coef_segmenter coef_segmenter_chk #(.COEF_W(COEF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .coef_valid (coef_valid),
  .coef_ready (coef_ready),
  .seg_valid  (seg_valid),
  .seg_exp    (seg_exp),
  .seg_neg    (seg_neg),
  .seg_zero   (seg_zero),
  .seg_resid  (seg_resid),
  .run_done   (run_done),
  .coef_q     (coef_q),
  .mode_q     (mode_q)
);

// File: tb/coef_segmenter_test.sv
`timescale 1ns/100ps
module coef_segmenter_test;
  localparam int W  = 16;
  localparam int L  = 8;
  localparam int EW = $clog2(W);

  logic          clk = 1'b0, rst = 1'b1;
  logic          coef_valid = 1'b0, seg_mode = 1'b0;
  logic [W-1:0]  coef_in = '0;
  logic          coef_ready, seg_valid, seg_neg, seg_zero, run_done;
  logic [EW-1:0] seg_exp;
  logic [W-1:0]  seg_resid;

  int  checks = 0, errors = 0, cyc = 0;
  bit  armed = 0;

  // reference model state
  bit    m_busy = 0, m_pend = 0, ev = 0, ed = 0, p_mode = 0, p_poked = 0;
  int    m_wait = 0, m_k = 0;
  int    p_e, p_n, p_z, p_r, p_h;
  int    ee = 0, en = 0, ez = 0, er = 0, eh = 0;
  string p_tag, etag = "R12";
  int    lcg = 32'h1234_5678;

  coef_segmenter #(.COEF_W(W), .NUM_COEF(L)) uut (
    .clk(clk), .rst(rst), .coef_valid(coef_valid), .coef_in(coef_in),
    .seg_mode(seg_mode), .coef_ready(coef_ready), .seg_valid(seg_valid),
    .seg_exp(seg_exp), .seg_neg(seg_neg), .seg_zero(seg_zero),
    .seg_resid(seg_resid), .run_done(run_done)
  );

  always #2.5 clk = ~clk;

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, expv);
    end
  endtask

  // behavioural segmentation from the requirements
  task automatic compute(input int h, input bit mode, output int e, output int n,
                         output int z, output int r, output int wt, output string tag);
    int a, i, p, hf;
    a = (h < 0) ? -h : h;
    i = 0;
    while ((1 << i) < a) i++;
    p = 1 << i; hf = p / 2; wt = i + 1;
    e = 0; n = 0; z = 0; r = 0;
    if (a == 0) begin
      z = 1; tag = "R8";
    end else if (!mode) begin
      if (p == a || (p - a) < (a - hf)) begin e = i; r = a - p; end
      else begin e = i - 1; r = a - hf; end
      if (h < 0) begin n = 1; r = -r; tag = "R4"; end else tag = "R3";
    end else if (p == a) begin
      e = i; n = (h < 0); tag = "R5";
    end else if (h > 0) begin
      e = i - 1; r = h - hf; tag = "R6";
    end else begin
      e = i; n = 1; r = h + p; tag = "R7";
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_sim();
    end
    if (rst) begin
      m_busy = 0; m_wait = 0; m_k = 0; m_pend = 0; ev = 0; ed = 0;
    end else begin
      ed = m_pend; m_pend = 0; ev = 0;
      if (m_busy) begin
        if (seg_mode != p_mode) p_poked = 1;
        m_wait--;
        if (m_wait == 0) begin
          ev = 1; ee = p_e; en = p_n; ez = p_z; er = p_r; eh = p_h;
          etag = p_poked ? "R11" : p_tag;
          m_busy = 0; m_k++;
          if (m_k == L) begin m_k = 0; m_pend = 1; end
        end
      end else if (coef_valid) begin
        p_h = int'($signed(coef_in));
        compute(p_h, seg_mode, p_e, p_n, p_z, p_r, m_wait, p_tag);
        p_mode = seg_mode; p_poked = 0; m_busy = 1;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (armed) begin
      check("R1 coef_ready", int'(coef_ready), int'(!m_busy));
      check("R2 seg_valid", int'(seg_valid), int'(ev));
      check("R10 run_done", int'(run_done), int'(ed));
      if (seg_valid && ev) begin
        check({etag, " seg_exp"}, int'(seg_exp), ee);
        check({etag, " seg_neg"}, int'(seg_neg), en);
        check({etag, " seg_zero"}, int'(seg_zero), ez);
        check({etag, " seg_resid"}, int'($signed(seg_resid)), er);
        if (!seg_zero)
          check("R9 recombined", (seg_neg ? -(1 << seg_exp) : (1 << seg_exp))
                + int'($signed(seg_resid)), eh);
      end
    end
  end

  task automatic send(input int h, input bit m, input bit poke);
    @(negedge clk);
    coef_valid = 1; coef_in = W'(h); seg_mode = m;
    while (!coef_ready) @(negedge clk);
    @(negedge clk);
    coef_valid = 0;
    if (poke) begin
      // R11: junk offered and rule flipped during the search
      coef_valid = 1; seg_mode = ~m; coef_in = ~coef_in;
      @(negedge clk);
      coef_valid = 0;
    end
  endtask

  initial begin
    int dir[] = '{0, 1, -1, 2, -2, 3, -3, 4, -4, 5, -5, 6, -6, 7, -7, 12, -12,
                  24, -24, 1000, -1000, 16384, -16384, 32767, -32767, -32768, 12288};
    rst = 1;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 seg_valid", int'(seg_valid), 0);
    check("R12 run_done", int'(run_done), 0);
    check("R12 seg_resid", int'(seg_resid), 0);
    check("R12 seg_exp", int'(seg_exp), 0);
    check("R12 coef_ready", int'(coef_ready), 1);
    rst = 0; armed = 1;
    for (int md = 0; md < 2; md++)
      foreach (dir[j]) send(dir[j], md[0], 1'b0);
    for (int j = 0; j < 12; j++) send(dir[j * 2] + 9, j[0], 1'b1);
    // partial set, then R12 reset mid-run restarts the count
    for (int j = 0; j < 3; j++) send(17 + j, 1'b0, 1'b0);
    repeat (25) @(negedge clk);
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    for (int j = 0; j < 300; j++) begin
      int h;
      lcg = lcg * 1103515245 + 12345;
      h = int'($signed(lcg[30:15]));
      h = h >>> (lcg[3:0] % 14);
      send(h, lcg[7], lcg[9] && lcg[11]);
    end
    repeat (40) @(negedge clk);
    finish_sim();
  end

endmodule